// File: doc/BRIEF.md
# Mesh Router Output-Port Selector with Bounded Broadcast

This block decides where each packet goes as it passes through one router of a two-dimensional cluster mesh. It sits between one incoming flit stream and the router's five outgoing directions (local, north, south, east, west). The first flit of every packet is decoded to produce an output-port set. That set is held for the whole packet and released once the flit marked as the last one has been transferred. Flits pass straight through with no added storage, so the output data equals the input data in the same cycle.

Two kinds of packet exist, and bit 0 of the header flit tells them apart. Unicast packets carry destination cluster coordinates in their most significant bits. They are steered with dimension-ordered routing: the X coordinate is corrected first, then Y, and the packet is delivered locally on arrival. Broadcast packets carry a rectangle of clusters. They travel along the X row, spread north and south in every column inside the rectangle, and are delivered locally in every cluster inside it.

Back-pressure rules:
- A flit is transferred only in a cycle where every port in the current set has `out_ready` high. Only then are the selected `out_valid` bits raised, and `in_ready` is raised at the same moment.
- `out_valid` therefore depends combinationally on `out_ready`. A receiver must not wait for valid before asserting ready.
- An empty port set is possible for broadcasts. In that case `in_ready` stays high and the flits are drained without being presented anywhere.

Top module: `mesh_route_sel`

## Requirements
- R1: After reset with no input flit offered, every `out_valid` bit is 0. The port-set bit order is [0] local, [1] north, [2] south, [3] east, [4] west. North means increasing Y and east means increasing X.
- R2: A header flit with bit 0 = 0 is unicast. Its destination X is the top XW bits of the flit and its destination Y is the next YW bits below. If destination X is greater than `here_x` the packet goes east, and if it is less the packet goes west.
- R3: For unicast with destination X equal to `here_x`: destination Y greater than `here_y` selects north, less selects south, and equal selects local.
- R4: Every unicast header selects exactly one port.
- R5: A header with bit 0 = 1 is broadcast. Its bounds sit from the top of the flit downward as BW-bit fields in the order x_lo, x_hi, y_lo, y_hi. A broadcast arriving from local or from west (`in_side` 0 or 4) goes east when `here_x` < x_hi. One arriving from local or from east (`in_side` 0 or 3) goes west when `here_x` > x_lo.
- R6: When x_lo <= `here_x` <= x_hi, a broadcast goes north if `here_y` < y_hi and it arrived from local, east, west or south (`in_side` 0, 3, 4, 2). It goes south if `here_y` > y_lo and it arrived from local, east, west or north (`in_side` 0, 3, 4, 1). A broadcast is never sent back toward its arrival side.
- R7: A broadcast is delivered on the local port exactly when `here_x` lies in [x_lo, x_hi] and `here_y` lies in [y_lo, y_hi].
- R8: While any port in the current set has `out_ready` low, `in_ready` is 0 and every `out_valid` bit is 0. When all are ready, `in_ready` is 1 and `out_valid` equals the set.
- R9: The port set is fixed by the first flit. Later flits of the same packet follow it whatever their contents and whatever `in_side`, `here_x` and `here_y` do. A new set is decoded after a flit with `in_eop` = 1 is transferred.
- R10: A broadcast whose set is empty has every flit accepted (`in_ready` = 1) with all `out_valid` bits 0.
- R11: `in_side` codes 5 to 7 behave as code 0 (local origin).
- R12: `out_flit` and `out_eop` equal `in_flit` and `in_eop` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| here_x | input | XW | X coordinate of this router |
| here_y | input | YW | Y coordinate of this router |
| in_side | input | 3 | Arrival side of the stream: 0 local, 1 north, 2 south, 3 east, 4 west |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Input flit taken this cycle |
| in_flit | input | FLIT_W | Input flit data |
| in_eop | input | 1 | Input flit is the last of its packet |
| out_valid | output | 5 | Per-port valid, bit order local, north, south, east, west |
| out_ready | input | 5 | Per-port ready, same bit order |
| out_flit | output | FLIT_W | Flit presented to the selected ports |
| out_eop | output | 1 | Last-flit flag presented to the selected ports |

## Verification
The bench builds the block with 3-bit X and Y coordinates, 5-bit broadcast bounds and 40-bit flits. Narrow coordinates make equal-coordinate cases, boundary rows and columns, and routers outside the rectangle frequent under random stimulus. The 5-bit bounds can still exceed any reachable coordinate, and reversed bounds (x_lo > x_hi) arise as well. With these values every arrival side meets both interior and edge routers, and empty broadcast sets and partial-ready stalls occur many times within a few hundred packets.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int NPORT = 5;
  localparam int P_LOC = 0;
  localparam int P_N   = 1;
  localparam int P_S   = 2;
  localparam int P_E   = 3;
  localparam int P_W   = 4;

  typedef enum logic [2:0] {
    SIDE_LOC = 3'd0,
    SIDE_N   = 3'd1,
    SIDE_S   = 3'd2,
    SIDE_E   = 3'd3,
    SIDE_W   = 3'd4
  } side_e;

  typedef logic [NPORT-1:0] pmask_t;

  function automatic side_e norm_side(input logic [2:0] raw);
    if (raw > 3'd4) return SIDE_LOC;
    return side_e'(raw);
  endfunction
endpackage

// File: rtl/mrs_unicast.sv
module mrs_unicast
  import mrs_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 5
) (
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  output pmask_t        mask
);
  always_comb begin
    mask = '0;
    if (dst_x > here_x)      mask[P_E]   = 1'b1;
    else if (dst_x < here_x) mask[P_W]   = 1'b1;
    else if (dst_y > here_y) mask[P_N]   = 1'b1;
    else if (dst_y < here_y) mask[P_S]   = 1'b1;
    else                     mask[P_LOC] = 1'b1;
  end

  always_comb begin
    if (!$isunknown({dst_x, dst_y, here_x, here_y}))
      assert_uc_onehot_R4: assert ($onehot(mask));
  end
endmodule

// File: rtl/mrs_bcast.sv
module mrs_bcast
  import mrs_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 5,
  parameter int BW = 5
) (
  input  logic [BW-1:0] x_lo,
  input  logic [BW-1:0] x_hi,
  input  logic [BW-1:0] y_lo,
  input  logic [BW-1:0] y_hi,
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  input  side_e         side,
  output pmask_t        mask
);
  logic [BW-1:0] hx, hy;
  logic x_in, y_in, on_trunk;

  assign hx = BW'(here_x);
  assign hy = BW'(here_y);

  always_comb begin
    x_in     = (hx >= x_lo) && (hx <= x_hi);
    y_in     = (hy >= y_lo) && (hy <= y_hi);
    on_trunk = (side == SIDE_LOC) || (side == SIDE_E) || (side == SIDE_W);
    mask = '0;
    mask[P_E]   = ((side == SIDE_LOC) || (side == SIDE_W)) && (hx < x_hi);
    mask[P_W]   = ((side == SIDE_LOC) || (side == SIDE_E)) && (hx > x_lo);
    mask[P_N]   = x_in && (on_trunk || (side == SIDE_S)) && (hy < y_hi);
    mask[P_S]   = x_in && (on_trunk || (side == SIDE_N)) && (hy > y_lo);
    mask[P_LOC] = x_in && y_in;
  end

  always_comb begin
    if (!$isunknown({x_lo, x_hi, y_lo, y_hi, here_x, here_y, side}) && side != SIDE_LOC)
      assert_no_backflow_R6: assert (!mask[side]);
  end
endmodule

// File: rtl/mrs_hold.sv
module mrs_hold
  import mrs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pmask_t fresh,
  input  logic   fire,
  input  logic   eop,
  output pmask_t mask
);
  logic   busy;
  pmask_t held;

  assign mask = busy ? held : fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      held <= '0;
    end else if (fire) begin
      if (eop) begin
        busy <= 1'b0;
      end else if (!busy) begin
        busy <= 1'b1;
        held <= fresh;
      end
    end
  end

  assert_route_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !eop) |=> (mask == $past(mask)));
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
  import mrs_pkg::*;
#(
  parameter int FLIT_W = 40,
  parameter int XW     = 5,
  parameter int YW     = 5,
  parameter int BW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XW-1:0]     here_x,
  input  logic [YW-1:0]     here_y,
  input  logic [2:0]        in_side,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              in_eop,
  output logic [NPORT-1:0]  out_valid,
  input  logic [NPORT-1:0]  out_ready,
  output logic [FLIT_W-1:0] out_flit,
  output logic              out_eop
);
  localparam int UX_HI = FLIT_W - 1;
  localparam int UY_HI = UX_HI - XW;
  localparam int BXL_HI = FLIT_W - 1;
  localparam int BXH_HI = BXL_HI - BW;
  localparam int BYL_HI = BXH_HI - BW;
  localparam int BYH_HI = BYL_HI - BW;

  pmask_t uc_mask, bc_mask, fresh, mask;
  logic   is_bc, fire;

  assign is_bc = in_flit[0];

  mrs_unicast #(.XW(XW), .YW(YW)) u_uc (
    .dst_x (in_flit[UX_HI -: XW]),
    .dst_y (in_flit[UY_HI -: YW]),
    .here_x(here_x),
    .here_y(here_y),
    .mask  (uc_mask)
  );

  mrs_bcast #(.XW(XW), .YW(YW), .BW(BW)) u_bc (
    .x_lo  (in_flit[BXL_HI -: BW]),
    .x_hi  (in_flit[BXH_HI -: BW]),
    .y_lo  (in_flit[BYL_HI -: BW]),
    .y_hi  (in_flit[BYH_HI -: BW]),
    .here_x(here_x),
    .here_y(here_y),
    .side  (norm_side(in_side)),
    .mask  (bc_mask)
  );

  assign fresh = is_bc ? bc_mask : uc_mask;

  mrs_hold u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .fresh(fresh),
    .fire (fire),
    .eop  (in_eop),
    .mask (mask)
  );

  assign in_ready = ((mask & ~out_ready) == '0);
  assign fire     = in_valid && in_ready;
  assign out_flit = in_flit;
  assign out_eop  = in_eop;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign out_valid[p] = in_valid && in_ready && mask[p];
  end

  assert_valid_needs_all_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> (in_valid && in_ready));
  assert_every_valid_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((out_valid & ~out_ready) == '0));
  assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (out_valid == '0));
endmodule

// File: tb/mesh_route_sel_test.sv
module mesh_route_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 40;
  localparam int XW = 3;
  localparam int YW = 3;
  localparam int BW = 5;

  logic clk = 0, rst_n = 0;
  logic [XW-1:0] here_x = 0;
  logic [YW-1:0] here_y = 0;
  logic [2:0] in_side = 0;
  logic in_valid = 0, in_ready, in_eop = 0, out_eop;
  logic [FW-1:0] in_flit = 0, out_flit;
  logic [4:0] out_valid, out_ready = 5'h1f;
  int checks = 0, failures = 0, cyc = 0;

  mesh_route_sel #(.FLIT_W(FW), .XW(XW), .YW(YW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y), .in_side(in_side),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit), .out_eop(out_eop));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  // Expected port set from the requirements; bit order L,N,S,E,W
  function automatic logic [4:0] ref_mask(input logic [FW-1:0] f, input logic [2:0] sd,
                                          input int hx, input int hy);
    logic [4:0] m = 0;
    int s = (sd > 4) ? 0 : sd;
    if (!f[0]) begin
      int dx = f[FW-1 -: XW];
      int dy = f[FW-1-XW -: YW];
      if (dx > hx) m[3] = 1;
      else if (dx < hx) m[4] = 1;
      else if (dy > hy) m[1] = 1;
      else if (dy < hy) m[2] = 1;
      else m[0] = 1;
    end else begin
      int xl = f[FW-1 -: BW];
      int xh = f[FW-1-BW -: BW];
      int yl = f[FW-1-2*BW -: BW];
      int yh = f[FW-1-3*BW -: BW];
      bit xin = (hx >= xl) && (hx <= xh);
      bit yin = (hy >= yl) && (hy <= yh);
      bit trunk = (s == 0) || (s == 3) || (s == 4);
      m[3] = ((s == 0) || (s == 4)) && (hx < xh);
      m[4] = ((s == 0) || (s == 3)) && (hx > xl);
      m[1] = xin && (trunk || s == 2) && (hy < yh);
      m[2] = xin && (trunk || s == 1) && (hy > yl);
      m[0] = xin && yin;
    end
    return m;
  endfunction

  function automatic logic [FW-1:0] mk_uc(input int x, input int y);
    logic [FW-1:0] f = {$urandom, $urandom};
    f[FW-1 -: XW] = XW'(x);
    f[FW-1-XW -: YW] = YW'(y);
    f[0] = 1'b0;
    return f;
  endfunction

  function automatic logic [FW-1:0] mk_bc(input int xl, input int xh, input int yl, input int yh);
    logic [FW-1:0] f = {$urandom, $urandom};
    f[FW-1 -: BW] = BW'(xl);
    f[FW-1-BW -: BW] = BW'(xh);
    f[FW-1-2*BW -: BW] = BW'(yl);
    f[FW-1-3*BW -: BW] = BW'(yh);
    f[0] = 1'b1;
    return f;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // rmode: 0 all ready, 1 random ready, 2 first attempt withholds one selected port
  task automatic send_pkt(input logic [FW-1:0] hdr, input logic [2:0] sd, input int len,
                          input int rmode, input string tag);
    logic [4:0] exp = ref_mask(hdr, sd, here_x, here_y);
    for (int i = 0; i < len; i++) begin
      logic [FW-1:0] f = (i == 0) ? hdr : {$urandom, $urandom};
      bit taken = 0;
      int tries = 0;
      while (!taken) begin
        bit all;
        string t;
        @(negedge clk);
        in_valid = 1; in_flit = f; in_eop = (i == len - 1);
        in_side = (i == 0) ? sd : 3'($urandom);
        if (rmode == 2 && tries == 0 && exp != 0) out_ready = 5'h1f & ~(exp & (~exp + 5'd1));
        else if (rmode == 1 && $urandom_range(0, 2) == 0) out_ready = 5'($urandom);
        else out_ready = 5'h1f;
        #1;
        all = ((exp & ~out_ready) == 0);
        t = !all ? "R8" : (i > 0 ? "R9" : (exp == 0 ? "R10" : tag));
        chk(t, out_valid, all ? exp : 5'd0);
        chk(t, in_ready, all);
        chk("R12", out_flit, f);
        chk("R12", out_eop, in_eop);
        taken = all;
        tries++;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 5'h1f;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", out_valid, 5'd0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", out_valid, 5'd0);

    here_x = 3; here_y = 3;
    send_pkt(mk_uc(5, 1), 0, 1, 0, "R2");
    send_pkt(mk_uc(1, 6), 0, 2, 0, "R2");
    send_pkt(mk_uc(3, 6), 3, 1, 0, "R3");
    send_pkt(mk_uc(3, 0), 0, 1, 0, "R3");
    send_pkt(mk_uc(3, 3), 1, 1, 0, "R3");
    send_pkt(mk_uc(7, 3), 0, 1, 0, "R4");
    send_pkt(mk_bc(0, 7, 0, 7), 0, 1, 0, "R5");
    send_pkt(mk_bc(0, 7, 0, 7), 4, 1, 0, "R5");
    send_pkt(mk_bc(0, 7, 0, 7), 3, 1, 0, "R5");
    send_pkt(mk_bc(0, 7, 0, 7), 2, 1, 0, "R6");
    send_pkt(mk_bc(0, 7, 3, 3), 1, 1, 0, "R6");
    send_pkt(mk_bc(4, 7, 0, 7), 0, 1, 0, "R7");
    send_pkt(mk_bc(0, 5, 4, 6), 0, 1, 0, "R7");
    send_pkt(mk_bc(0, 2, 0, 7), 4, 3, 0, "R10");
    send_pkt(mk_bc(0, 7, 0, 7), 6, 1, 0, "R11");
    send_pkt(mk_bc(0, 7, 0, 7), 0, 2, 2, "R8");
    send_pkt(mk_uc(0, 0), 0, 4, 2, "R9");

    for (int n = 0; n < 400; n++) begin
      logic [FW-1:0] h;
      @(negedge clk);
      here_x = 3'($urandom); here_y = 3'($urandom);
      if ($urandom_range(0, 1) == 0)
        h = mk_uc($urandom_range(0, 7), $urandom_range(0, 7));
      else
        h = mk_bc($urandom_range(0, 9), $urandom_range(0, 9),
                  $urandom_range(0, 9), $urandom_range(0, 9));
      send_pkt(h, 3'($urandom), $urandom_range(1, 4), 1, h[0] ? "R6" : "R2");
    end

    @(negedge clk); #1;
    chk("R1", out_valid, 5'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule